// File: doc/BRIEF.md
# Flash Page Erase Sequencer

This block sits in front of an on-chip flash array and runs page erases for software. Software reaches it through a small register port. A protection register holds one bit per sector. A control register takes a page number, and writing it starts an erase. A status register reports whether an erase is running and how the last one ended.

Toward the array the block gives a one-cycle start pulse and holds the page number. It then waits for the array to report completion together with a pass or fail flag. A cycle counter bounds the wait. Its default length equals a 350 ms worst case at the configured clock. While an erase is running, the block stalls any request that arrives on the flash data port.

An erase is refused, and nothing reaches the array, in two cases: the page number lies outside the array, or the page's sector is still protected. Both refusals are reported as a failed erase. A write to the control register while an erase is running is dropped silently.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, status reads 0 (idle, erase-ok clear), every protection bit reads 1, `arr_erase` is low and `dp_wait` is low.
- R2: Register address 1 holds the protection mask in bits [SECTORS-1:0]; it can be written at any time, and its upper bits read as 0.
- R3: A write to address 2 while idle, naming a legal page (wdata[7:0] < SECTORS*PAGES_PER_SECTOR) whose sector (page / PAGES_PER_SECTOR) has its protection bit at 0, raises `arr_erase` for exactly one cycle after the write. In that same cycle the status busy field (bits [1:0]) reads 01 and `arr_page` equals the page.
- R4: While busy, writes to address 2 are ignored: no new pulse, and `arr_page` keeps its value.
- R5: An idle write to address 2 naming a page in a protected sector issues no pulse, leaves busy at 00 and clears erase-ok (status bit 2).
- R6: An idle write to address 2 naming a page at or beyond SECTORS*PAGES_PER_SECTOR issues no pulse, leaves busy at 00 and clears erase-ok.
- R7: While busy is 01, `dp_wait` follows `dp_req`; while idle, `dp_wait` is low.
- R8: When `arr_done` is sampled high during an erase, busy reads 00 in the next cycle and erase-ok holds the sampled `arr_pass`. Erase-ok then keeps that value until the next idle write to address 2.
- R9: If `arr_done` has not arrived after ERASE_LIMIT busy cycles, the erase ends with busy 00 and erase-ok 0. A done in the final busy cycle still counts.
- R10: Setting protection bits to 1 during an erase does not abort it or change its result.
- R11: `arr_done` while idle changes neither busy nor erase-ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 2 | Register select: 0 status, 1 protection, 2 control |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Read data for `csr_addr`, combinational |
| dp_req | input | 1 | A read or write is pending on the data port |
| dp_wait | output | 1 | Stall for the data port |
| arr_erase | output | 1 | One-cycle erase start toward the array |
| arr_page | output | PAGE_FIELD_W | Page being erased |
| arr_done | input | 1 | Array reports that the erase has finished |
| arr_pass | input | 1 | Array result, valid with `arr_done` |

## Verification
The assertions check the cycle-level rules on every clock. They cover the start pulse after an accepted write, the refusal of illegal or protected pages, the frozen page number while busy, the capture of the result one cycle after done, the stall at the start of an erase, and the bound on busy length. Other behaviour only shows over the bench's scenarios: the exact timeout length against a late done, the survival of an erase after its sector is protected again, the protection readback, and erase-ok holding its value across idle done pulses. The random erases mix protection masks, legal and illegal pages, and response delays on both sides of the limit.

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int SECTORS          = 4,
  parameter int PAGES_PER_SECTOR = 8,
  parameter int PAGE_FIELD_W     = 8,
  parameter int DATA_W           = 32,
  parameter int CLK_HZ           = 125_000_000,
  parameter int ERASE_MS         = 350,
  parameter int ERASE_LIMIT      = CLK_HZ / 1000 * ERASE_MS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              csr_addr,
  input  logic                    csr_wr,
  input  logic [DATA_W-1:0]       csr_wdata,
  output logic [DATA_W-1:0]       csr_rdata,
  input  logic                    dp_req,
  output logic                    dp_wait,
  output logic                    arr_erase,
  output logic [PAGE_FIELD_W-1:0] arr_page,
  input  logic                    arr_done,
  input  logic                    arr_pass
);
  localparam int NUM_PAGES = SECTORS * PAGES_PER_SECTOR;
  localparam int TMR_W     = $clog2(ERASE_LIMIT + 1);

  logic                    busy_q, ok_q, erase_q;
  logic [SECTORS-1:0]      prot_q;
  logic [PAGE_FIELD_W-1:0] page_q;
  logic [TMR_W-1:0]        tmr_q;

  logic [PAGE_FIELD_W-1:0] page_in;
  logic ctl_wr, legal, sec_prot, start, reject, finish, timeout;

  assign page_in = csr_wdata[PAGE_FIELD_W-1:0];
  assign ctl_wr  = csr_wr && csr_addr == 2'd2;
  assign legal   = page_in < PAGE_FIELD_W'(NUM_PAGES);

  always_comb begin
    sec_prot = 1'b1;
    for (int s = 0; s < SECTORS; s++)
      if (page_in >= PAGE_FIELD_W'(s * PAGES_PER_SECTOR)) sec_prot = prot_q[s];
  end

  assign start   = ctl_wr && !busy_q && legal && !sec_prot;
  assign reject  = ctl_wr && !busy_q && !start;
  assign finish  = busy_q && arr_done;
  assign timeout = busy_q && !arr_done && tmr_q == TMR_W'(ERASE_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ok_q    <= 1'b0;
      erase_q <= 1'b0;
      prot_q  <= '1;
      page_q  <= '0;
      tmr_q   <= '0;
    end else begin
      erase_q <= start;
      if (csr_wr && csr_addr == 2'd1) prot_q <= csr_wdata[SECTORS-1:0];
      if (start) begin
        busy_q <= 1'b1;
        page_q <= page_in;
        tmr_q  <= '0;
      end else if (reject) begin
        ok_q <= 1'b0;
      end else if (finish) begin
        busy_q <= 1'b0;
        ok_q   <= arr_pass;
      end else if (timeout) begin
        busy_q <= 1'b0;
        ok_q   <= 1'b0;
      end else if (busy_q) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (csr_addr)
      2'd0:    csr_rdata = DATA_W'({ok_q, 1'b0, busy_q});
      2'd1:    csr_rdata = DATA_W'(prot_q);
      default: csr_rdata = '0;
    endcase
  end

  assign dp_wait   = busy_q & dp_req;
  assign arr_erase = erase_q;
  assign arr_page  = page_q;
endmodule

module flash_erase_seq_chk #(
  parameter int SECTORS          = 4,
  parameter int PAGES_PER_SECTOR = 8,
  parameter int PAGE_FIELD_W     = 8,
  parameter int DATA_W           = 32,
  parameter int ERASE_LIMIT      = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              csr_addr,
  input logic                    csr_wr,
  input logic [DATA_W-1:0]       csr_wdata,
  input logic                    dp_req,
  input logic                    dp_wait,
  input logic                    arr_erase,
  input logic [PAGE_FIELD_W-1:0] arr_page,
  input logic                    arr_done,
  input logic                    arr_pass,
  input logic                    busy,
  input logic                    ok,
  input logic [SECTORS-1:0]      prot
);
  logic [PAGE_FIELD_W-1:0] pg, sec_num;
  logic [SECTORS-1:0]      shifted;
  logic                    idle_ctl, in_range, go;
  int unsigned             busy_len;

  assign pg       = csr_wdata[PAGE_FIELD_W-1:0];
  assign sec_num  = pg / PAGE_FIELD_W'(PAGES_PER_SECTOR);
  assign shifted  = prot >> sec_num;
  assign in_range = int'(pg) < SECTORS * PAGES_PER_SECTOR;
  assign idle_ctl = csr_wr && csr_addr == 2'd2 && !busy;
  assign go       = idle_ctl && in_range && !shifted[0];

  always_ff @(posedge clk)
    if (!rst_n || !busy) busy_len <= 0;
    else busy_len <= busy_len + 1;

  // R3
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> arr_erase && busy && arr_page == $past(pg));
  // R4
  busy_page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(arr_page) && !arr_erase);
  // R5
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_ctl && !go) |=> !busy && !ok && !arr_erase);
  // R7
  stall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase && dp_req) |-> dp_wait);
  // R8
  done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && arr_done) |=> !busy && !dp_wait && ok == $past(arr_pass));
  // R9
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_len < ERASE_LIMIT);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !idle_ctl) |=> !busy && $stable(ok));
endmodule

bind flash_erase_seq flash_erase_seq_chk #(
  .SECTORS(SECTORS), .PAGES_PER_SECTOR(PAGES_PER_SECTOR),
  .PAGE_FIELD_W(PAGE_FIELD_W), .DATA_W(DATA_W), .ERASE_LIMIT(ERASE_LIMIT)
) chk (
  .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .dp_req(dp_req), .dp_wait(dp_wait),
  .arr_erase(arr_erase), .arr_page(arr_page), .arr_done(arr_done),
  .arr_pass(arr_pass), .busy(busy_q), .ok(ok_q), .prot(prot_q)
);

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
  localparam int LIM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic        csr_wr = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        dp_req = 1'b0, dp_wait;
  logic        arr_erase, arr_done = 1'b0, arr_pass = 1'b0;
  logic [7:0]  arr_page;

  int errs = 0, nchk = 0;
  logic [3:0] prot_m;
  logic       ok_m;

  always #4 clk = ~clk;

  flash_erase_seq #(.ERASE_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wr(csr_wr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .dp_req(dp_req),
    .dp_wait(dp_wait), .arr_erase(arr_erase), .arr_page(arr_page),
    .arr_done(arr_done), .arr_pass(arr_pass));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic accept_exp(input int page, input logic [3:0] prot);
    return page < 32 && !prot[page / 8];
  endfunction

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    csr_addr = a;
    #1 v = csr_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic set_prot(input logic [3:0] p);
    wr(2'd1, 32'(p));
    prot_m = p;
  endtask

  task automatic run_erase(input string rtag, input int page, input int d,
                           input logic pass, input logic reprot, input logic interfere);
    logic acc, stall_ok, page_ok, pulse_seen, reprot_done, exp_ok;
    logic [31:0] v;
    int fin;
    acc = accept_exp(page, prot_m);
    dp_req = 1'b1;
    wr(2'd2, 32'(page));
    chk({rtag, " start pulse"}, 32'(arr_erase), 32'(acc));
    rd(2'd0, v);
    chk({rtag, " busy after write"}, 32'(v[1:0]), acc ? 32'd1 : 32'd0);
    chk("R7 stall at start", 32'(dp_wait), 32'(acc));
    if (!acc) begin
      ok_m = 1'b0;
      chk({rtag, " erase-ok cleared"}, 32'(v[2]), 32'd0);
      dp_req = 1'b0;
      return;
    end
    chk("R3 page", 32'(arr_page), 32'(page));
    fin = (d <= LIM) ? d : LIM;
    stall_ok = 1'b1; page_ok = 1'b1; pulse_seen = 1'b0; reprot_done = 1'b0;
    for (int i = 1; i < fin; i++) begin
      @(negedge clk);
      if (!dp_wait) stall_ok = 1'b0;
      if (arr_erase) pulse_seen = 1'b1;
      if (arr_page !== 8'(page)) page_ok = 1'b0;
      csr_wr = 1'b0;
      if (i == 1 && reprot) begin
        csr_addr = 2'd1; csr_wdata = '1; csr_wr = 1'b1; reprot_done = 1'b1;
      end
      if (i == 2 && interfere) begin
        csr_addr = 2'd2; csr_wdata = 32'((page + 1) % 32); csr_wr = 1'b1;
      end
    end
    if (d <= LIM) begin arr_done = 1'b1; arr_pass = pass; end
    @(negedge clk);
    csr_wr = 1'b0; arr_done = 1'b0;
    if (reprot_done) prot_m = 4'hF;
    chk("R7 stall held while busy", 32'(stall_ok), 32'd1);
    chk("R4 no second pulse", 32'(pulse_seen), 32'd0);
    chk("R4 page held", 32'(page_ok && arr_page == 8'(page)), 32'd1);
    exp_ok = (d <= LIM) ? pass : 1'b0;
    rd(2'd0, v);
    chk(d <= LIM ? "R8 busy back to idle" : "R9 timeout idle", 32'(v[1:0]), 32'd0);
    chk(d <= LIM ? "R8 result" : "R9 timeout fail", 32'(v[2]), 32'(exp_ok));
    chk("R7 no stall when idle", 32'(dp_wait), 32'd0);
    ok_m = exp_ok;
    if (d > LIM) begin
      arr_done = 1'b1; arr_pass = 1'b1;
      @(negedge clk);
      arr_done = 1'b0;
      rd(2'd0, v);
      chk("R11 late done ignored", 32'(v[2:0]), 32'd0);
    end
    if (reprot_done) begin
      rd(2'd1, v);
      chk("R10 protect readback", v, 32'hF);
      chk("R10 erase completed", 32'(ok_m), 32'(pass));
    end
    dp_req = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    prot_m = 4'hF; ok_m = 1'b0;
    @(negedge clk);
    dp_req = 1'b1;
    rd(2'd0, v); chk("R1 status", v, 32'd0);
    rd(2'd1, v); chk("R1 protect", v, 32'hF);
    chk("R1 pulse", 32'(arr_erase), 32'd0);
    chk("R1 stall", 32'(dp_wait), 32'd0);
    dp_req = 1'b0;

    set_prot(4'h5); rd(2'd1, v); chk("R2 readback", v, 32'h5);
    wr(2'd1, 32'hFFFF_FFFF); prot_m = 4'hF;
    rd(2'd1, v); chk("R2 upper bits", v, 32'hF);

    run_erase("R5", 3, 5, 1'b1, 1'b0, 1'b0);
    set_prot(4'h0);
    run_erase("R3", 3, 5, 1'b1, 1'b0, 1'b0);
    run_erase("R3", 12, 1, 1'b0, 1'b0, 1'b0);
    run_erase("R3", 31, 2, 1'b1, 1'b0, 1'b0);
    run_erase("R6", 32, 3, 1'b1, 1'b0, 1'b0);
    run_erase("R6", 200, 3, 1'b1, 1'b0, 1'b0);
    set_prot(4'h4);
    run_erase("R5", 17, 3, 1'b1, 1'b0, 1'b0);
    run_erase("R3", 8, 4, 1'b1, 1'b0, 1'b0);
    run_erase("R9", 5, LIM + 6, 1'b1, 1'b0, 1'b0);
    run_erase("R9", 6, LIM, 1'b1, 1'b0, 1'b0);
    set_prot(4'h0);
    run_erase("R10", 20, 10, 1'b1, 1'b1, 1'b1);

    @(negedge clk);
    arr_done = 1'b1; arr_pass = ~ok_m;
    @(negedge clk);
    arr_done = 1'b0;
    rd(2'd0, v);
    chk("R11 idle done", 32'(v[2:0]), {29'd0, ok_m, 2'b00});
    chk("R11 no pulse", 32'(arr_erase), 32'd0);

    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 3) == 0) set_prot(4'($urandom_range(0, 15)));
      run_erase("R3 random", int'($urandom_range(0, 39)), int'($urandom_range(1, LIM + 8)),
                1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)));
    end

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule